// File: doc/BRIEF.md
# Current-Sense ADC Register Front-End

This block is the byte-wide register file and control sequencer of a current-sense ADC peripheral. A host issues single-byte reads and writes at 8-bit offsets. Through these it reads identification values, sets the operating mode, trim, channel, decimation, settle delay and averaging, turns the peripheral on and off, and starts conversions. When a conversion is done, the host collects a 16-bit result from two byte registers. A two-bit status field reports progress, and a single-cycle interrupt pulse marks completion.

The analog converter is replaced by a behavioural stub. A conversion lasts `(BASE_CYC + settle) << avg_log2` cycles, and the shift applies only while averaging is enabled. At the end, the stub latches the `sample_in` input as the result. One reset-control register is guarded by a key. A write to it takes effect only when the write just before it put 0xA5 at offset 0xD0. Reads between the two writes do not break the unlock.

Top module: `cadc_frontend`

## Requirements
- R1: Reads of the identification offsets return fixed values: 0x04 returns 0x08, 0x05 returns 0x03, and 0x01 returns REV_VAL (default 1). Unmapped offsets read 0x00.
- R2: Configuration registers read back what was written, under these masks: 0x40 keeps bits 7:3 (mode, where 0 is normal) and bit 0 (trim); 0x46 keeps bit 7 (enable); 0x48 keeps all 8 bits (channel); 0x50 keeps bits 7:2 (decimation, where 0 means 512); 0x51 keeps all 8 bits (settle delay); 0x5A keeps bits 2:0 (averaging count as log2); 0x5B keeps bit 7 (averaging enable).
- R3: Writing a byte with bit 7 set to 0x52 while enabled starts a conversion. Status at offset 0x08 has request-pending at bit 1 and end-of-conversion at bit 0. It reads 0x02 from the cycle after the request edge. Exactly L = (8 + settle) << (avg_en ? avg_log2 : 0) edges after the request, it reads 0x01, which is the only pattern that means complete.
- R4: At completion, the result at 0x60 (low byte) and 0x61 (high byte) equals `sample_in` as it was at the completing edge. The result does not change at any other time.
- R5: `eoc_irq` is high for exactly one cycle, which is the first cycle in which status reads 0x01.
- R6: A read of 0x60 returns the low result byte and clears end-of-conversion, so status then reads 0x00. A read of 0x61 leaves status unchanged.
- R7: A conversion request written while bit 7 of 0x46 is clear is ignored. Status keeps its previous value and no interrupt occurs.
- R8: Writing 0x46 with bit 7 clear during a conversion cancels it. Status reads 0x00 afterwards, no interrupt follows, and the result keeps its old value.
- R9: A conversion request written while one is pending is ignored. Completion still comes L edges after the first request.
- R10: A write to 0xDA updates bit 2 (`follow_warm`, which reads back at bit 2 and drives the output) only when the preceding write put 0xA5 at 0xD0. Reads in between are allowed. Other bits of 0xDA read as 0.
- R11: A write to 0xDA is rejected, leaving the register unchanged, if no key was written first, if the key value was wrong, if another write came between, or if the unlock was already used by an earlier write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for one byte |
| host_rd | input | 1 | Read strobe (read side effects) |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| sample_in | input | 16 | Converter stub input value latched at completion |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| follow_warm | output | 1 | Follow-warm-reset control bit |

## Verification
Conversions run under directed and random settle delays and averaging settings. The completion edge is compared to the computed latency, which separates the base, settle and averaging terms of the timing. Random `sample_in` values show whether each result byte lands at the right offset. Requests issued when disabled, when pending and when cancelled separate the three ways a request can be refused or dropped. Key sequences use the right key, a wrong key, an interposed write, an interposed read and a reused unlock, which shows exactly when the unlock is consumed.

// File: rtl/cadc_pkg.sv
`timescale 1ns/1ps
package cadc_pkg;
    localparam logic [7:0] A_REV    = 8'h01;
    localparam logic [7:0] A_TYPE   = 8'h04;
    localparam logic [7:0] A_SUB    = 8'h05;
    localparam logic [7:0] A_STAT   = 8'h08;
    localparam logic [7:0] A_MODE   = 8'h40;
    localparam logic [7:0] A_EN     = 8'h46;
    localparam logic [7:0] A_CHAN   = 8'h48;
    localparam logic [7:0] A_DIG    = 8'h50;
    localparam logic [7:0] A_SETTLE = 8'h51;
    localparam logic [7:0] A_REQ    = 8'h52;
    localparam logic [7:0] A_AVGN   = 8'h5a;
    localparam logic [7:0] A_AVGEN  = 8'h5b;
    localparam logic [7:0] A_RES_LO = 8'h60;
    localparam logic [7:0] A_RES_HI = 8'h61;
    localparam logic [7:0] A_KEY    = 8'hd0;
    localparam logic [7:0] A_RSTCTL = 8'hda;

    localparam logic [7:0] KEY_VAL  = 8'ha5;
    localparam logic [7:0] TYPE_VAL = 8'h08;
    localparam logic [7:0] SUB_VAL  = 8'h03;

    localparam int CNT_W = 24;
    localparam int RES_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DONE = 2'b01,
        ST_PEND = 2'b10
    } stat_e;

    typedef struct packed {
        logic [4:0] op_mode;
        logic       trim;
        logic       en;
        logic [7:0] chan;
        logic [5:0] decim;
        logic [7:0] settle;
        logic [2:0] avg_log2;
        logic       avg_en;
    } cfg_t;

    function automatic logic [CNT_W-1:0] conv_cycles(input logic [7:0] base,
                                                     input cfg_t c);
        logic [CNT_W-1:0] t;
        t = CNT_W'(base) + CNT_W'(c.settle);
        if (c.avg_en) t = t << c.avg_log2;
        return t;
    endfunction
endpackage

// File: rtl/cadc_cfg_regs.sv
`timescale 1ns/1ps
module cadc_cfg_regs
    import cadc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (addr)
                A_MODE: begin
                    cfg.op_mode <= wdata[7:3];
                    cfg.trim    <= wdata[0];
                end
                A_EN:     cfg.en       <= wdata[7];
                A_CHAN:   cfg.chan     <= wdata;
                A_DIG:    cfg.decim    <= wdata[7:2];
                A_SETTLE: cfg.settle   <= wdata;
                A_AVGN:   cfg.avg_log2 <= wdata[2:0];
                A_AVGEN:  cfg.avg_en   <= wdata[7];
                default: ;
            endcase
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(cfg));
endmodule

// File: rtl/cadc_keylock.sv
`timescale 1ns/1ps
module cadc_keylock
    import cadc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       warm
);
    logic unlock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= 1'b0;
            warm     <= 1'b0;
        end else if (wr) begin
            unlock_q <= (addr == A_KEY) && (wdata == KEY_VAL);
            if (addr == A_RSTCTL && unlock_q) warm <= wdata[2];
        end
    end

    // R11
    warm_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(warm) |-> ($past(unlock_q) && $past(wr)));
endmodule

// File: rtl/cadc_conv.sv
`timescale 1ns/1ps
module cadc_conv
    import cadc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             req_strobe,
    input  logic             dis_strobe,
    input  logic             rd_lo,
    input  logic [CNT_W-1:0] cycles,
    input  logic [RES_W-1:0] sample_in,
    output stat_e            stat,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat   <= ST_IDLE;
            cnt    <= '0;
            result <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (dis_strobe) begin
                if (stat == ST_PEND) stat <= ST_IDLE;
            end else if (stat == ST_PEND) begin
                if (cnt <= CNT_W'(1)) begin
                    stat   <= ST_DONE;
                    result <= sample_in;
                    irq    <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end else if (req_strobe && en) begin
                stat <= ST_PEND;
                cnt  <= cycles;
            end else if (rd_lo && stat == ST_DONE) begin
                stat <= ST_IDLE;
            end
        end
    end

    // R5
    irq_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat == ST_DONE);
    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R8
    dis_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> stat != ST_PEND);
    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> irq);
    // R9
    pend_count_chk: assert property (@(posedge clk) disable iff (rst)
        (stat == ST_PEND && $past(stat) == ST_PEND) |-> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/cadc_frontend.sv
`timescale 1ns/1ps
module cadc_frontend
    import cadc_pkg::*;
#(
    parameter int BASE_CYC = 8,
    parameter int REV_VAL  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic [RES_W-1:0] sample_in,
    output logic             eoc_irq,
    output logic             follow_warm
);
    localparam logic [7:0] BASE_B = 8'(BASE_CYC);
    localparam logic [7:0] REV_B  = 8'(REV_VAL);

    cfg_t             cfg;
    stat_e            stat;
    logic [RES_W-1:0] result;
    logic             req_strobe, dis_strobe, rd_lo;

    assign req_strobe = host_wr && host_addr == A_REQ && host_wdata[7];
    assign dis_strobe = host_wr && host_addr == A_EN && !host_wdata[7];
    assign rd_lo      = host_rd && host_addr == A_RES_LO;

    cadc_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .cfg(cfg)
    );

    cadc_keylock u_key (
        .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .warm(follow_warm)
    );

    cadc_conv u_conv (
        .clk(clk), .rst(rst), .en(cfg.en), .req_strobe(req_strobe),
        .dis_strobe(dis_strobe), .rd_lo(rd_lo),
        .cycles(conv_cycles(BASE_B, cfg)), .sample_in(sample_in),
        .stat(stat), .result(result), .irq(eoc_irq)
    );

    always_comb begin
        case (host_addr)
            A_REV:    host_rdata = REV_B;
            A_TYPE:   host_rdata = TYPE_VAL;
            A_SUB:    host_rdata = SUB_VAL;
            A_STAT:   host_rdata = {6'b0, stat};
            A_MODE:   host_rdata = {cfg.op_mode, 2'b0, cfg.trim};
            A_EN:     host_rdata = {cfg.en, 7'b0};
            A_CHAN:   host_rdata = cfg.chan;
            A_DIG:    host_rdata = {cfg.decim, 2'b0};
            A_SETTLE: host_rdata = cfg.settle;
            A_REQ:    host_rdata = {stat == ST_PEND, 7'b0};
            A_AVGN:   host_rdata = {5'b0, cfg.avg_log2};
            A_AVGEN:  host_rdata = {cfg.avg_en, 7'b0};
            A_RES_LO: host_rdata = result[7:0];
            A_RES_HI: host_rdata = result[15:8];
            A_RSTCTL: host_rdata = {5'b0, follow_warm, 2'b0};
            default:  host_rdata = 8'h00;
        endcase
    end
endmodule

// File: tb/sim_cadc_frontend.sv
`timescale 1ns/1ps
module sim_cadc_frontend;
    localparam logic [7:0] R_REV = 8'h01, R_TYPE = 8'h04, R_SUB = 8'h05, R_STAT = 8'h08;
    localparam logic [7:0] R_MODE = 8'h40, R_EN = 8'h46, R_CHAN = 8'h48, R_DIG = 8'h50;
    localparam logic [7:0] R_SET = 8'h51, R_REQ = 8'h52, R_AVN = 8'h5a, R_AVE = 8'h5b;
    localparam logic [7:0] R_LO = 8'h60, R_HI = 8'h61, R_KEY = 8'hd0, R_RCT = 8'hda;
    localparam int BASE = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, host_wr, host_rd, eoc_irq, follow_warm;
    logic [7:0] host_addr, host_wdata, host_rdata;
    logic [15:0] sample_in;

    cadc_frontend u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sample_in(sample_in), .eoc_irq(eoc_irq), .follow_warm(follow_warm)
    );

    int n_chk = 0, n_fail = 0, ecount = 0;
    logic [7:0] cur_set = 0;
    logic [2:0] cur_lg = 0;
    logic cur_ae = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        ecount++;
        #1 host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic q);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata; q = eoc_irq;
        @(posedge clk);
        ecount++;
        #1 host_rd = 1'b0;
    endtask

    function automatic logic [7:0] rmask(input logic [7:0] a);
        case (a)
            R_MODE: return 8'hf9;
            R_EN, R_AVE: return 8'h80;
            R_CHAN, R_SET: return 8'hff;
            R_DIG: return 8'hfc;
            R_AVN: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int lat(input logic [7:0] s, input logic ae, input logic [2:0] lg);
        int t;
        t = BASE + int'(s);
        if (ae) t = t << lg;
        return t;
    endfunction

    task automatic setup(input logic [7:0] s, input logic ae, input logic [2:0] lg);
        wr(R_SET, s); wr(R_AVN, {5'b0, lg}); wr(R_AVE, {ae, 7'b0});
        cur_set = s; cur_ae = ae; cur_lg = lg;
    endtask

    // poll status from request edge e0 until completion at L edges (R3, R5)
    task automatic poll_done(input int e0, input int L, input string tag);
        logic [7:0] d; logic q; int el;
        for (int i = 0; i < L + 4; i++) begin
            el = ecount - e0;
            rd(R_STAT, d, q);
            if (el < L) begin
                if (d !== 8'h02 || q !== 1'b0) begin
                    check({tag, " R3 pending"}, {d, 7'b0, q}, {8'h02, 8'h00});
                    break;
                end
            end else begin
                check({tag, " R3 done status"}, d, 8'h01);
                check({tag, " R3 done edge"}, el, L);
                check({tag, " R5 irq pulse"}, q, 1'b1);
                break;
            end
        end
    endtask

    task automatic run_conv(input logic [15:0] smp, input string tag);
        logic [7:0] d; logic q; int e0;
        sample_in = smp;
        wr(R_REQ, 8'h80);
        e0 = ecount;
        poll_done(e0, lat(cur_set, cur_ae, cur_lg), tag);
        rd(R_HI, d, q);   check({tag, " R4 hi"}, d, smp[15:8]);
        check({tag, " R5 irq low"}, q, 1'b0);
        rd(R_STAT, d, q); check({tag, " R6 hi keeps eoc"}, d, 8'h01);
        rd(R_LO, d, q);   check({tag, " R4 lo"}, d, smp[7:0]);
        rd(R_STAT, d, q); check({tag, " R6 lo clears"}, d, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d; logic q; int e0; logic [15:0] prev;
        void'($urandom(32'd1234));
        rst = 1'b1; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0; sample_in = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        rd(R_STAT, d, q); check("reset status", d, 8'h00);
        check("reset irq", q, 1'b0);
        rd(R_LO, d, q);   check("reset result", d, 8'h00);
        check("reset follow_warm", follow_warm, 1'b0);

        // R1 identification
        rd(R_TYPE, d, q); check("R1 type", d, 8'h08);
        rd(R_SUB, d, q);  check("R1 subtype", d, 8'h03);
        rd(R_REV, d, q);  check("R1 revision", d, 8'h01);
        rd(8'h02, d, q);  check("R1 unmapped", d, 8'h00);
        rd(8'h77, d, q);  check("R1 unmapped", d, 8'h00);

        // R2 random readback of configuration registers
        for (int i = 0; i < 30; i++) begin
            logic [7:0] a, v;
            case ($urandom % 6)
                0: a = R_MODE; 1: a = R_CHAN; 2: a = R_DIG;
                3: a = R_SET;  4: a = R_AVN;  default: a = R_AVE;
            endcase
            v = 8'($urandom);
            wr(a, v);
            rd(a, d, q);
            check("R2 readback", d, v & rmask(a));
        end
        wr(R_EN, 8'h7f); rd(R_EN, d, q); check("R2 enable mask", d, 8'h00);

        wr(R_EN, 8'h80);
        setup(8'd0, 1'b0, 3'd0);
        run_conv(16'h1234, "dir0");
        setup(8'd3, 1'b1, 3'd2);
        run_conv(16'hA55A, "dir1");
        for (int i = 0; i < 15; i++) begin
            setup(8'($urandom % 16), 1'($urandom), 3'($urandom % 4));
            run_conv(16'($urandom), "rand");
        end

        // R7 request while disabled
        setup(8'd2, 1'b0, 3'd0);
        sample_in = 16'h0F0F;
        wr(R_REQ, 8'h80); e0 = ecount;
        poll_done(e0, 10, "r7 prep");
        wr(R_EN, 8'h00);
        wr(R_REQ, 8'h80);
        for (int i = 0; i < 12; i++) begin
            rd(R_STAT, d, q);
            if (d !== 8'h01 || q !== 1'b0) begin
                check("R7 disabled request ignored", {d, q}, {8'h01, 1'b0});
                break;
            end
        end
        check("R7 status kept", d, 8'h01);
        wr(R_EN, 8'h00); wr(R_REQ, 8'h80);
        rd(R_LO, d, q);   check("R7 result", d, 8'h0F);
        rd(R_STAT, d, q); check("R7 idle stays idle", d, 8'h00);
        wr(R_REQ, 8'h80);
        rd(R_STAT, d, q); check("R7 idle request ignored", d, 8'h00);

        // R8 cancel
        wr(R_EN, 8'h80);
        setup(8'd20, 1'b0, 3'd0);
        prev = 16'h0F0F;
        sample_in = 16'hBEEF;
        wr(R_REQ, 8'h80);
        rd(R_STAT, d, q); check("R8 pending before cancel", d, 8'h02);
        wr(R_EN, 8'h00);
        for (int i = 0; i < 40; i++) begin
            rd(R_STAT, d, q);
            if (d !== 8'h00 || q !== 1'b0) begin
                check("R8 cancelled", {d, q}, {8'h00, 1'b0});
                break;
            end
        end
        check("R8 status idle", d, 8'h00);
        rd(R_LO, d, q); check("R8 result lo kept", d, prev[7:0]);
        rd(R_HI, d, q); check("R8 result hi kept", d, prev[15:8]);

        // R9 request while pending
        wr(R_EN, 8'h80);
        setup(8'd10, 1'b0, 3'd0);
        sample_in = 16'h5678;
        wr(R_REQ, 8'h80); e0 = ecount;
        rd(R_STAT, d, q); rd(R_REQ, d, q);
        check("R9 pending readback", d, 8'h80);
        wr(R_REQ, 8'h80);
        poll_done(e0, lat(8'd10, 1'b0, 3'd0), "R9");
        rd(R_LO, d, q); check("R9 result", d, 8'h78);

        // R10 key unlock
        wr(R_KEY, 8'hA5); wr(R_RCT, 8'h04);
        rd(R_RCT, d, q); check("R10 unlocked write", d, 8'h04);
        check("R10 follow_warm out", follow_warm, 1'b1);
        wr(R_KEY, 8'hA5); rd(R_STAT, d, q); wr(R_RCT, 8'h00);
        rd(R_RCT, d, q); check("R10 read between", d, 8'h00);
        wr(R_KEY, 8'hA5); wr(R_RCT, 8'hFF);
        rd(R_RCT, d, q); check("R10 only bit 2", d, 8'h04);

        // R11 rejected writes
        wr(R_RCT, 8'h00);
        rd(R_RCT, d, q); check("R11 reused unlock", d, 8'h04);
        wr(R_KEY, 8'h5A); wr(R_RCT, 8'h00);
        rd(R_RCT, d, q); check("R11 wrong key", d, 8'h04);
        wr(R_KEY, 8'hA5); wr(R_CHAN, 8'h01); wr(R_RCT, 8'h00);
        rd(R_RCT, d, q); check("R11 write between", d, 8'h04);
        check("R11 follow_warm out", follow_warm, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule